// File: doc/BRIEF.md
# Dual-Function Parallel I/O Port

This block owns nine bidirectional pad lines. Software chooses, pin by pin, whether a line is a general-purpose parallel I/O line or belongs to an on-chip serial peripheral. The choice is made through a small register bus that has an address, a write strobe, write data and combinational read data.

Three registers are visible on the bus. The function register holds one bit per pin: a 0 keeps the pin in parallel mode and a 1 hands it to the serial peripheral. The direction register holds one bit per pin and applies only in parallel mode: a 0 makes the pin an input and a 1 makes it an output. The level register has a split role. A write loads the output latch that parallel outputs drive. A read returns the pad levels as they are now, after they have passed through a two-flop synchronizer. For a pin in serial mode, the output value and output enable are taken directly from the peripheral signals for that pin.

Top module: `pport_top`

## Requirements
- R1: While reset is high and after it, the function, direction and level-latch registers are zero. Every pin is therefore a parallel input, with pin_oe = 0 and pin_out = 0.
- R2: A write with bus_wr = 1 at address 0 loads bus_wdata[8:0] into the function register. A read at address 0 returns that value, and bus_rdata[15:9] always reads 0.
- R3: A write at address 1 loads bus_wdata[8:0] into the direction register. A read at address 1 returns that value.
- R4: When function bit i is 0, pin_oe[i] equals direction bit i.
- R5: When function bit i is 0, pin_out[i] equals bit i of the last value written at address 2.
- R6: When function bit i is 1, pin_out[i] follows per_out[i] and pin_oe[i] follows per_oe[i] in the same cycle. The direction and latch bits for that pin have no effect on it.
- R7: A read at address 2 returns pin_in as it stood two rising clock edges earlier. It does not return the latched write value.
- R8: Address 3 always reads 0. A write to address 3 changes no register.
- R9: When bus_wr = 0, no register changes, whatever the address and write data.
- R10: A value written at address 2 while a pin is an input is held. It appears on pin_out with pin_oe = 1 once the direction bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 function, 1 direction, 2 level, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| pin_in | input | 9 | Pad input levels |
| pin_out | output | 9 | Pad output values |
| pin_oe | output | 9 | Pad output enables |
| per_out | input | 9 | Serial peripheral output value per pin |
| per_oe | input | 9 | Serial peripheral output enable per pin |

## Verification
The latency check on level reads assumes that pin_in is free of glitches between clock edges and that at least three edges have passed since time zero. Before that, the synchronizer flops hold undefined values. The bench models each pad as the driven value when pin_oe is high and as an external level otherwise. It changes the external level, the peripheral signals and the bus only on falling edges. It then sweeps all 512 function patterns against arithmetically varied direction, latch, peripheral and external values.

// File: rtl/pport_pkg.sv
package pport_pkg;
    localparam int NPINS  = 9;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;
    localparam int PAD_W  = DATA_W - NPINS;

    typedef logic [NPINS-1:0] pin_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_FUNC  = 2'd0,
        RA_DIR   = 2'd1,
        RA_LEVEL = 2'd2,
        RA_NONE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        pin_vec_t func;
        pin_vec_t dir;
        pin_vec_t latch;
    } port_cfg_t;

    function automatic logic [DATA_W-1:0] widen(input pin_vec_t v);
        return {{PAD_W{1'b0}}, v};
    endfunction
endpackage

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output port_cfg_t            cfg
);
    port_cfg_t cfg_q;
    reg_addr_e sel_addr;

    assign sel_addr = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (sel_addr)
                RA_FUNC:  cfg_q.func  <= wdata[NPINS-1:0];
                RA_DIR:   cfg_q.dir   <= wdata[NPINS-1:0];
                RA_LEVEL: cfg_q.latch <= wdata[NPINS-1:0];
                default:  ;
            endcase
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        meta_q <= d;
        stab_q <= meta_q;
    end

    assign q = stab_q;
endmodule

// File: rtl/pport_route.sv
module pport_route
    import pport_pkg::*;
(
    input  port_cfg_t cfg,
    input  pin_vec_t  per_out,
    input  pin_vec_t  per_oe,
    output pin_vec_t  pin_out,
    output pin_vec_t  pin_oe
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        always_comb begin
            if (cfg.func[i]) begin
                pin_out[i] = per_out[i];
                pin_oe[i]  = per_oe[i];
            end else begin
                pin_out[i] = cfg.latch[i];
                pin_oe[i]  = cfg.dir[i];
            end
        end
    end
endmodule

// File: rtl/pport_top.sv
module pport_top
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    input  logic [NPINS-1:0]  per_out,
    input  logic [NPINS-1:0]  per_oe
);
    port_cfg_t cfg_q;
    pin_vec_t  lvl_sync;

    pport_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .cfg   (cfg_q)
    );

    pport_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .d   (pin_in),
        .q   (lvl_sync)
    );

    pport_route u_route (
        .cfg     (cfg_q),
        .per_out (per_out),
        .per_oe  (per_oe),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    always_comb begin
        case (reg_addr_e'(bus_addr))
            RA_FUNC:  bus_rdata = widen(cfg_q.func);
            RA_DIR:   bus_rdata = widen(cfg_q.dir);
            RA_LEVEL: bus_rdata = widen(lvl_sync);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pport_chk.sv
module pport_chk
    import pport_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NPINS-1:0]  pin_in,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  per_out,
    input logic [NPINS-1:0]  per_oe,
    input port_cfg_t         cfg
);
    logic [1:0] age = 2'd0;

    always_ff @(posedge clk) begin
        if (age != 2'd3) age <= age + 2'd1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) |-> (pin_oe == '0 && cfg == '0)); // R1
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst) bus_rdata[DATA_W-1:NPINS] == '0); // R2
    AST_FUNC_WRITE: assert property (@(posedge clk) disable iff (rst) (bus_wr && bus_addr == 2'd0) |=> cfg.func == $past(bus_wdata[NPINS-1:0])); // R2
    AST_PAR_OE: assert property (@(posedge clk) disable iff (rst) ((~cfg.func & pin_oe) == (~cfg.func & cfg.dir))); // R4
    AST_SER_ROUTE: assert property (@(posedge clk) disable iff (rst) ((cfg.func & pin_out) == (cfg.func & per_out)) && ((cfg.func & pin_oe) == (cfg.func & per_oe))); // R6
    AST_LEVEL_LAT: assert property (@(posedge clk) disable iff (rst) (age == 2'd3 && bus_addr == 2'd2) |-> bus_rdata[NPINS-1:0] == $past(pin_in, 2)); // R7
    AST_NONE_ZERO: assert property (@(posedge clk) disable iff (rst) (bus_addr == 2'd3) |-> bus_rdata == '0); // R8
    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst) !bus_wr |=> $stable(cfg)); // R9
endmodule

bind pport_top pport_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .per_out   (per_out),
    .per_oe    (per_oe),
    .cfg       (cfg_q)
);

// File: tb/sim_pport_top.sv
module sim_pport_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 9;
    localparam logic [NP-1:0] ALL = '1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [NP-1:0] pin_in, pin_out, pin_oe;
    logic [NP-1:0] per_out = '0, per_oe = '0, ext = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

    pport_top u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .per_out(per_out), .per_oe(per_oe)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] r;
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 oe in reset", {7'd0, pin_oe}, 16'd0);
        check("R1 out in reset", {7'd0, pin_out}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        rd(2'd0, r); check("R1 func reset", r, 16'd0);
        rd(2'd1, r); check("R1 dir reset", r, 16'd0);

        // R7 two-edge latency
        ext = 9'h000;
        repeat (3) @(negedge clk);
        ext = 9'h1AB;
        @(negedge clk);
        rd(2'd2, r); check("R7 after one edge", r, 16'h0000);
        @(negedge clk);
        rd(2'd2, r); check("R7 after two edges", r, 16'h01AB);

        // R10 latch held while input
        wr(2'd2, 16'hFEF0);
        check("R10 oe while input", {7'd0, pin_oe}, 16'd0);
        check("R5 out latch", {7'd0, pin_out}, 16'h00F0);
        rd(2'd2, r); check("R7 read is pin not latch", r, 16'h01AB);
        wr(2'd1, 16'hFFFF);
        check("R10 oe after dir", {7'd0, pin_oe}, 16'h01FF);
        check("R10 out after dir", {7'd0, pin_out}, 16'h00F0);
        rd(2'd1, r); check("R3 dir readback masked", r, 16'h01FF);

        // R8 unused address
        wr(2'd3, 16'h0155);
        rd(2'd3, r); check("R8 read zero", r, 16'd0);
        rd(2'd0, r); check("R8 func untouched", r, 16'd0);
        rd(2'd1, r); check("R8 dir untouched", r, 16'h01FF);
        check("R8 latch untouched", {7'd0, pin_out}, 16'h00F0);

        // R9 no strobe
        @(negedge clk);
        bus_addr = 2'd0; bus_wdata = 16'h01FF; bus_wr = 1'b0;
        @(negedge clk);
        rd(2'd0, r); check("R9 func no strobe", r, 16'd0);
        bus_addr = 2'd2;
        @(negedge clk);
        check("R9 latch no strobe", {7'd0, pin_out}, 16'h00F0);

        // Sweep over every function pattern (R2 R4 R5 R6 R7)
        for (int k = 0; k < 512; k++) begin
            logic [NP-1:0] f, d, l, po, pe, eo, eoe, elv;
            f  = NP'(k);
            d  = NP'(k * 37);
            l  = NP'(k * 101 + 7);
            po = NP'(k * 53 + 3);
            pe = NP'((k * 29) ^ 16'h155);
            @(negedge clk);
            per_out = po; per_oe = pe; ext = NP'(k * 211 + 9);
            wr(2'd0, {7'h5A, f});
            wr(2'd1, {7'h33, d});
            wr(2'd2, {7'h7F, l});
            eo  = (f & po) | (~f & l);
            eoe = (f & pe) | (~f & d);
            elv = (eoe & eo) | (~eoe & ext);
            check("R5 R6 pin_out", {7'd0, pin_out}, {7'd0, eo});
            check("R4 R6 pin_oe", {7'd0, pin_oe}, {7'd0, eoe});
            rd(2'd0, r); check("R2 func readback", r, {7'd0, f});
            rd(2'd1, r); check("R3 dir readback", r, {7'd0, d});
            @(negedge clk); @(negedge clk);
            rd(2'd2, r); check("R7 level read", r, {7'd0, elv});
        end

        // R1 reset again clears
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 oe after reset", {7'd0, pin_oe}, 16'd0);
        rd(2'd1, r); check("R1 dir after reset", r, 16'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule